// File: doc/BRIEF.md
# Flash Write-Status Polling Responder

This block produces the status that a NOR flash presents on its data bus while an internal program or erase job is running. A start pulse launches a job. The pulse marks the rising edge of the final write-enable pulse of the command sequence. Along with the pulse come the job type, the data bit that the job writes onto bit 7, and a flag that says the target is protected. From the next clock on, the block drives a polled status bit (bit 7 of the data bus). It also drives an active-low ready/busy line, passes a plain exceeded-limit input through as status bit 5, and pulses an indication when the part returns to read mode.

Programs return the inverted target bit while they run and the true bit once finished. Erases return zero while they run and one once finished or suspended. A job aimed at protected storage does not run. Instead it holds a fake-busy window and then falls back with the stored data unchanged. The window lasts one microsecond for a program and one hundred microseconds for an erase, each converted to clock cycles from `CLK_HZ` and rounded up. An erase in which only some sectors are protected is started as a normal erase with the protect flag low. Its protected sectors are reported through the address-valid input, so reads from them are flagged invalid.

Top module: `flash_status_responder`

## Requirements
- R1: After reset the ready/busy line is high (ready), the return-to-read pulse is low, and no status is valid, even with a qualified read.
- R2: From the cycle after an unprotected program start until the cycle after `done_i`, ready/busy is low and polled bit 7 is the inverse of the target bit. Afterwards read mode returns the target bit itself.
- R3: From the cycle after an unprotected erase start, ready/busy is low and polled bit 7 is 0. After `done_i`, read mode returns 1.
- R4: While an erase runs, a high `suspend_i` moves the block to a suspended state on the next clock. In that state ready/busy is high and bit 7 reads 1. Dropping `suspend_i` resumes the erase, with bit 7 back at 0 and busy.
- R5: A program started while the erase is suspended is busy and returns the inverse target bit. On `done_i` it goes back to the suspended state, not to read mode.
- R6: A protected program stays busy for exactly ceil(CLK_HZ/1e6) cycles, returning the inverse target bit. It then reaches read mode with the earlier read result unchanged.
- R7: A protected erase stays busy for exactly ceil(CLK_HZ/1e4) cycles with bit 7 at 0, then reaches read mode.
- R8: `dq_valid_o` is 1 only when `rd_i` and `addr_ok_i` are both high and either a job state is active or a finished result exists. Whenever `dq_valid_o` is 0, `dq7_o` is 0.
- R9: `to_read_o` is high for exactly the one cycle after every entry into read mode from a job. It stays low on entry into the suspended state.
- R10: A start while busy is ignored, an erase start while suspended is ignored, and `done_i` has no effect during a protected window.
- R11: `dq5_o` follows `limit_i` while busy and is 0 whenever ready/busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle job launch (final write pulse edge) |
| op_erase_i | input | 1 | Job type: 1 erase, 0 program |
| tgt_bit_i | input | 1 | Data bit the program writes onto bit 7 |
| prot_i | input | 1 | Target protected (program) or all selected sectors protected (erase) |
| suspend_i | input | 1 | Erase-suspend request, level sensitive |
| rd_i | input | 1 | Read strobe |
| addr_ok_i | input | 1 | Read address is a valid status address |
| done_i | input | 1 | Internal job completion |
| limit_i | input | 1 | Exceeded-limit condition driven onto bit 5 |
| dq7_o | output | 1 | Polled status bit 7 |
| dq_valid_o | output | 1 | Status on bit 7 is valid for this read |
| ry_by_n_o | output | 1 | Ready (1) / busy (0) |
| to_read_o | output | 1 | One-cycle pulse after returning to read mode |
| dq5_o | output | 1 | Exceeded-limit status bit 5 |

## Verification
The bench uses a clock rate that is not a whole number of megahertz, so both protected windows need rounding up. A window that is one cycle short or one cycle long, or that truncates instead of rounding up, shows up as a wrong busy count. The bench sends a second start while a program runs, an erase start while suspended, and a completion inside a protected window. A design that accepted any of these would change bit 7 or release busy early. Reads at an invalid address and a protected fallback after an earlier good result catch a block that drives stale data or overwrites the stored result. A program that completes inside a suspend catches a block that drops to read mode instead of returning to the suspended erase.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_PSUSP = 3'd4,
        ST_GUARD = 3'd5
    } fsr_state_e;

    typedef struct packed {
        fsr_state_e st;
        logic       bit_tgt;
        logic       is_erase;
        logic       back_susp;
        logic       result;
        logic       res_ok;
        logic       to_read;
    } fsr_regs_t;
endpackage

// File: rtl/fsr_guard_timer.sv
module fsr_guard_timer #(
    parameter int PROG_LEN  = 1,
    parameter int ERASE_LEN = 100,
    localparam int CW = $clog2(ERASE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic erase_i,
    output logic expired_o
);
    localparam logic [CW-1:0] P_LD = CW'(PROG_LEN - 1);
    localparam logic [CW-1:0] E_LD = CW'(ERASE_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = erase_i ? E_LD : P_LD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= E_LD);
    assert_cnt_descends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fsr_dq_mux.sv
module fsr_dq_mux
    import fsr_pkg::*;
(
    input  fsr_state_e st_i,
    input  logic       bit_tgt_i,
    input  logic       is_erase_i,
    input  logic       result_i,
    input  logic       res_ok_i,
    input  logic       rd_i,
    input  logic       addr_ok_i,
    input  logic       limit_i,
    output logic       dq7_o,
    output logic       dq_valid_o,
    output logic       ry_by_n_o,
    output logic       dq5_o
);
    logic busy, val, avail;

    always_comb begin
        busy = 1'b0;
        val  = 1'b0;
        unique case (st_i)
            ST_READ:  val = result_i;
            ST_PROG:  begin busy = 1'b1; val = ~bit_tgt_i; end
            ST_PSUSP: begin busy = 1'b1; val = ~bit_tgt_i; end
            ST_ERASE: begin busy = 1'b1; val = 1'b0; end
            ST_SUSP:  val = 1'b1;
            ST_GUARD: begin busy = 1'b1; val = is_erase_i ? 1'b0 : ~bit_tgt_i; end
            default:  begin busy = 1'b0; val = 1'b0; end
        endcase
        avail      = (st_i != ST_READ) || res_ok_i;
        dq_valid_o = rd_i && addr_ok_i && avail;
        dq7_o      = dq_valid_o && val;
        ry_by_n_o  = ~busy;
        dq5_o      = busy && limit_i;
    end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    localparam int PROG_LEN  = (CLK_HZ + 999_999) / 1_000_000,
    localparam int ERASE_LEN = (CLK_HZ + 9_999) / 10_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic op_erase_i,
    input  logic tgt_bit_i,
    input  logic prot_i,
    input  logic suspend_i,
    input  logic rd_i,
    input  logic addr_ok_i,
    input  logic done_i,
    input  logic limit_i,
    output logic dq7_o,
    output logic dq_valid_o,
    output logic ry_by_n_o,
    output logic to_read_o,
    output logic dq5_o
);
    fsr_regs_t r_d, r_q;
    logic      load, expired;

    always_comb begin
        r_d         = r_q;
        r_d.to_read = 1'b0;
        load        = 1'b0;
        unique case (r_q.st)
            ST_READ: begin
                if (start_i) begin
                    r_d.bit_tgt   = tgt_bit_i;
                    r_d.is_erase  = op_erase_i;
                    r_d.back_susp = 1'b0;
                    if (prot_i) begin
                        r_d.st = ST_GUARD;
                        load   = 1'b1;
                    end else begin
                        r_d.st = op_erase_i ? ST_ERASE : ST_PROG;
                    end
                end
            end
            ST_SUSP: begin
                if (start_i && !op_erase_i) begin
                    r_d.bit_tgt   = tgt_bit_i;
                    r_d.is_erase  = 1'b0;
                    r_d.back_susp = 1'b1;
                    if (prot_i) begin
                        r_d.st = ST_GUARD;
                        load   = 1'b1;
                    end else begin
                        r_d.st = ST_PSUSP;
                    end
                end else if (!suspend_i) begin
                    r_d.st = ST_ERASE;
                end
            end
            ST_PROG: begin
                if (done_i) begin
                    r_d.st      = ST_READ;
                    r_d.result  = r_q.bit_tgt;
                    r_d.res_ok  = 1'b1;
                    r_d.to_read = 1'b1;
                end
            end
            ST_PSUSP: begin
                if (done_i) begin
                    r_d.st     = ST_SUSP;
                    r_d.result = r_q.bit_tgt;
                    r_d.res_ok = 1'b1;
                end
            end
            ST_ERASE: begin
                if (done_i) begin
                    r_d.st      = ST_READ;
                    r_d.result  = 1'b1;
                    r_d.res_ok  = 1'b1;
                    r_d.to_read = 1'b1;
                end else if (suspend_i) begin
                    r_d.st = ST_SUSP;
                end
            end
            ST_GUARD: begin
                if (expired) begin
                    r_d.st      = r_q.back_susp ? ST_SUSP : ST_READ;
                    r_d.to_read = ~r_q.back_susp;
                end
            end
            default: r_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_READ, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    fsr_guard_timer #(
        .PROG_LEN  (PROG_LEN),
        .ERASE_LEN (ERASE_LEN)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .erase_i   (op_erase_i),
        .expired_o (expired)
    );

    fsr_dq_mux u_mux (
        .st_i       (r_q.st),
        .bit_tgt_i  (r_q.bit_tgt),
        .is_erase_i (r_q.is_erase),
        .result_i   (r_q.result),
        .res_ok_i   (r_q.res_ok),
        .rd_i       (rd_i),
        .addr_ok_i  (addr_ok_i),
        .limit_i    (limit_i),
        .dq7_o      (dq7_o),
        .dq_valid_o (dq_valid_o),
        .ry_by_n_o  (ry_by_n_o),
        .dq5_o      (dq5_o)
    );

    assign to_read_o = r_q.to_read;

    assert_prog_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG) |-> !ry_by_n_o);
    assert_erase_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ERASE) |-> !dq7_o);
    assert_susp_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SUSP) |-> ry_by_n_o);
    assert_psusp_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PSUSP && done_i) |=> (r_q.st == ST_SUSP && !to_read_o));
    assert_invalid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid_o |-> !dq7_o);
    assert_read_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        to_read_o |=> !to_read_o);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG && !done_i) |=> (r_q.st == ST_PROG && r_q.bit_tgt == $past(r_q.bit_tgt)));
    assert_limit_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ry_by_n_o |-> !dq5_o);
endmodule

// File: tb/sim_flash_status_responder.sv
module sim_flash_status_responder;
    localparam int  CLK_PERIOD = 10;
    localparam int  HZ      = 12_345_678;
    localparam longint PROG_N  = (longint'(HZ) + 64'd999_999) / 64'd1_000_000;
    localparam longint ERASE_N = (longint'(HZ) * 100 + 64'd999_999) / 64'd1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, op_erase_i = 0, tgt_bit_i = 0, prot_i = 0, suspend_i = 0;
    logic rd_i = 0, addr_ok_i = 0, done_i = 0, limit_i = 0;
    logic dq7_o, dq_valid_o, ry_by_n_o, to_read_o, dq5_o;

    int errors = 0;
    int checks = 0;
    int busy_run = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_status_responder #(.CLK_HZ(HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .tgt_bit_i(tgt_bit_i), .prot_i(prot_i), .suspend_i(suspend_i), .rd_i(rd_i),
        .addr_ok_i(addr_ok_i), .done_i(done_i), .limit_i(limit_i), .dq7_o(dq7_o),
        .dq_valid_o(dq_valid_o), .ry_by_n_o(ry_by_n_o), .to_read_o(to_read_o), .dq5_o(dq5_o)
    );

    // Reference model: 0 read, 1 program, 2 erase, 3 suspended, 4 program in suspend, 5 guard
    int     m_st = 0;
    longint m_left = 0;
    bit m_bit = 0, m_er = 0, m_back = 0, m_res = 0, m_resok = 0, m_tr = 0;

    function automatic void model_step();
        m_tr = 0;
        case (m_st)
            0: if (start_i) begin
                m_bit = tgt_bit_i; m_er = op_erase_i; m_back = 0;
                if (prot_i) begin m_st = 5; m_left = op_erase_i ? ERASE_N : PROG_N; end
                else m_st = op_erase_i ? 2 : 1;
            end
            3: if (start_i && !op_erase_i) begin
                m_bit = tgt_bit_i; m_er = 0; m_back = 1;
                if (prot_i) begin m_st = 5; m_left = PROG_N; end
                else m_st = 4;
            end else if (!suspend_i) m_st = 2;
            1: if (done_i) begin m_st = 0; m_res = m_bit; m_resok = 1; m_tr = 1; end
            4: if (done_i) begin m_st = 3; m_res = m_bit; m_resok = 1; end
            2: if (done_i) begin m_st = 0; m_res = 1; m_resok = 1; m_tr = 1; end
               else if (suspend_i) m_st = 3;
            5: begin
                m_left--;
                if (m_left == 0) begin m_st = m_back ? 3 : 0; m_tr = !m_back; end
            end
            default: m_st = 0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string state_req();
        case (m_st)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return m_er ? "R7" : "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic compare();
        bit busy, val, avail, vld;
        busy  = (m_st == 1 || m_st == 2 || m_st == 4 || m_st == 5);
        case (m_st)
            0: val = m_res;
            1, 4: val = !m_bit;
            2: val = 0;
            3: val = 1;
            default: val = m_er ? 1'b0 : !m_bit;
        endcase
        avail = (m_st != 0) || m_resok;
        vld   = rd_i && addr_ok_i && avail;
        chk(state_req(), "ry_by_n", ry_by_n_o, !busy);
        chk("R8", "dq_valid", dq_valid_o, vld);
        chk(state_req(), "dq7", dq7_o, vld && val);
        chk("R9", "to_read", to_read_o, m_tr);
        chk("R11", "dq5", dq5_o, busy && limit_i);
        busy_run = busy ? busy_run + 1 : 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic launch(logic er, logic b, logic p);
        start_i = 1; op_erase_i = er; tgt_bit_i = b; prot_i = p;
        tick();
        start_i = 0; prot_i = 0;
    endtask

    task automatic finish_job();
        done_i = 1; tick(); done_i = 0;
    endtask

    initial begin
        rd_i = 1; addr_ok_i = 1;
        repeat (3) @(negedge clk);
        chk("R1", "reset ready", ry_by_n_o, 1'b1);
        chk("R1", "reset valid", dq_valid_o, 1'b0);
        chk("R1", "reset to_read", to_read_o, 1'b0);
        rst_n = 1;
        tick();

        // R2: program of bit 1, then a competing start (R10)
        launch(1'b0, 1'b1, 1'b0);
        chk("R2", "polled inverse", dq7_o, 1'b0);
        ticks(3);
        launch(1'b0, 1'b0, 1'b0);
        chk("R10", "start during program ignored", dq7_o, 1'b0);
        ticks(2);
        finish_job();
        chk("R9", "pulse after program", to_read_o, 1'b1);
        chk("R2", "true bit after program", dq7_o, 1'b1);
        tick();

        // R3/R11: erase with limit toggling
        launch(1'b1, 1'b0, 1'b0);
        limit_i = 1; ticks(2);
        chk("R11", "limit while busy", dq5_o, 1'b1);
        limit_i = 0; ticks(2);

        // R4/R5: suspend, program inside, erase start ignored (R10), resume
        suspend_i = 1; tick();
        chk("R4", "suspend ready", ry_by_n_o, 1'b1);
        limit_i = 1; tick(); limit_i = 0;
        launch(1'b1, 1'b0, 1'b0);
        chk("R10", "erase start in suspend ignored", ry_by_n_o, 1'b1);
        launch(1'b0, 1'b0, 1'b0);
        chk("R5", "program in suspend inverse", dq7_o, 1'b1);
        ticks(3);
        finish_job();
        chk("R5", "back to suspend", ry_by_n_o, 1'b1);
        chk("R9", "no pulse into suspend", to_read_o, 1'b0);
        ticks(2);
        suspend_i = 0; tick();
        chk("R4", "resumed erase", dq7_o, 1'b0);
        ticks(3);
        finish_job();
        chk("R3", "erase result", dq7_o, 1'b1);
        tick();

        // R8: invalid address while busy and idle
        addr_ok_i = 0; tick();
        chk("R8", "invalid addr idle", dq_valid_o, 1'b0);
        launch(1'b0, 1'b1, 1'b0);
        ticks(2);
        chk("R8", "invalid addr busy", dq7_o, 1'b0);
        addr_ok_i = 1;
        finish_job();
        tick();

        // R6: protected program, completion ignored inside window (R10)
        launch(1'b0, 1'b0, 1'b1);
        ticks(2);
        done_i = 1; tick(); done_i = 0;
        chk("R10", "done ignored in window", ry_by_n_o, 1'b0);
        while (!ry_by_n_o) tick();
        chk("R6", "window busy length", (busy_run == 0) ? 1'b1 : 1'b0, 1'b1);
        tick();
        chk("R6", "result unchanged", dq7_o, 1'b1);

        // R6 length measured explicitly
        begin
            int n = 0;
            launch(1'b0, 1'b1, 1'b1);
            while (!ry_by_n_o) begin n++; tick(); end
            checks++;
            if (n != PROG_N) begin errors++; $display("FAIL R6 window cycles: actual=%0d expected=%0d", n, PROG_N); end
        end
        // R7 protected erase length
        begin
            int n = 0;
            launch(1'b1, 1'b0, 1'b1);
            while (!ry_by_n_o) begin n++; tick(); end
            checks++;
            if (n != ERASE_N) begin errors++; $display("FAIL R7 window cycles: actual=%0d expected=%0d", n, ERASE_N); end
            chk("R7", "pulse after erase window", to_read_o, 1'b1);
        end
        ticks(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule